// File: doc/BRIEF.md
# Float Result Rounder with Flush-to-Zero

This block is the final stage of a single-precision arithmetic unit. It accepts an unrounded result and returns a packed binary32 word with four exception flags. The result arrives as a sign, a signed biased exponent of unbounded range, and a 27-bit significand. In that significand bit 26 is the integer bit, bits 25..3 are the fraction that is kept, and bits 2..0 are extra low-order bits; bit 2 serves as guard and bits 1..0 are ORed into sticky. A significand of zero stands for an exact zero. The value is (-1)^sign × inSig × 2^(inExp − 127 − 26), so inExp = 127 with inSig = 27'h4000000 means 1.0.

The block rounds in one of four modes. It denormalises results whose exponent lies below the normal range and saturates overflows to infinity or to the largest finite value. It can also flush tiny results to a signed zero. Two separate mode bits set when a result counts as tiny. One bit serves the underflow flag and the other serves the flush decision, so a flush decided before rounding can be combined with underflow tininess decided after rounding. The outputs pass through one register stage, so each result appears one clock after its input.

Top module: `fp_round_ftz`

## Requirements
- R1: outValid equals the inValid of the previous clock. Flags are zero whenever outValid is 0. A synchronous reset clears outValid and all flags.
- R2: The output word carries the sign in bit 31, the exponent field in bits 30..23 and the fraction in bits 22..0. rndMode selects the rounding: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward −infinity. A zero significand gives a zero of the input sign and no flags.
- R3: The inexact flag (flagInexact) is raised whenever a discarded bit is nonzero, on the normal path and on the denormal path alike.
- R4: If the rounded biased exponent exceeds 254, overflow and inexact are raised. The word becomes infinity when rounding goes away from zero for that sign (mode 0, mode 2 with positive sign, mode 3 with negative sign). In the other cases it becomes the largest finite value of that sign (exponent field 254, fraction all ones).
- R5: With flush disabled, an input exponent of 0 or less is rounded at the denormal grain (2^−149) and gives exponent field 0. If the rounding carries into the integer bit, the exponent field becomes 1, which is the smallest normal number.
- R6: If denormal rounding leaves both the exponent field and the fraction at zero, the output is a zero of the input sign.
- R7: With flush disabled, underflow is raised only for a tiny and inexact result. tinyBefore = 1 treats every input exponent of 0 or less as tiny. tinyBefore = 0 treats a result as tiny when rounding with an unbounded exponent gives an exponent below 1.
- R8: With flushEn = 1 and flushBefore = 1, every nonzero input whose exponent is 0 or less gives a signed zero. flagFlushed is raised and inexact and underflow stay clear. Exponents of 1 and above are rounded normally.
- R9: With flushEn = 1 and flushBefore = 0, the result is first rounded as a denormal, with inexact set from that rounding. If it is tiny after rounding, it becomes a signed zero with flagFlushed set. Otherwise the rounded value is kept. Underflow is never raised while flush is enabled.
- R10: The flush timing bit and the tininess bit act independently. tinyBefore has no effect while flush is enabled, and flushBefore has no effect while flush is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input result is present this cycle |
| inSign | input | 1 | Sign of the unrounded result |
| inExp | input | 10 | Signed biased exponent, unbounded |
| inSig | input | 27 | Significand: integer bit 26, kept fraction 25..3, guard 2, sticky 1..0 |
| rndMode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward −inf |
| flushEn | input | 1 | Flush tiny results to zero |
| flushBefore | input | 1 | Flush tininess: 1 before rounding, 0 after rounding |
| tinyBefore | input | 1 | Underflow tininess: 1 before rounding, 0 after rounding |
| outValid | output | 1 | Output word and flags are valid |
| outWord | output | 32 | Packed binary32 result |
| flagOverflow | output | 1 | Overflow flag |
| flagUnderflow | output | 1 | Underflow flag |
| flagInexact | output | 1 | Inexact flag |
| flagFlushed | output | 1 | Output was flushed to zero |

## Verification
Normal results are tried with guard-only and sticky-only discards and with ties at odd and at even LSBs, under all four modes and both signs. These tell the rounding modes apart and show that a tie goes to the even neighbour. Overflow is driven from a carry out of the rounder and from exponents well above range, with each mode and sign, to tell saturation to infinity from saturation to the largest finite value. Sub-normal inputs sit at exponent 0, at the last denormal grain and far below it. One input, 1.111…1 with the guard set at exponent 0, rounds to the smallest normal. It tells before-rounding tininess from after-rounding tininess, and it tells before-rounding flush from after-rounding flush. The same inputs are repeated with the unused mode bit flipped to show that each bit acts alone.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rnd_mode_e;

  // result selection strobes from control to datapath
  typedef struct packed {
    logic zero;
    logic denorm;
    logic inf;
    logic maxFin;
  } sel_t;

  // exception flag strobes
  typedef struct packed {
    logic of;
    logic uf;
    logic nx;
    logic fz;
  } flags_t;

  // decide whether to add one ulp to the kept bits
  function automatic logic roundInc(rnd_mode_e mode, logic sign, logic lsb,
                                    logic guard, logic sticky);
    logic inc;
    case (mode)
      RND_NEAR_EVEN: inc = guard && (sticky || lsb);
      RND_ZERO:      inc = 1'b0;
      RND_UP:        inc = !sign && (guard || sticky);
      default:       inc = sign && (guard || sticky);
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/fp_round_dp.sv
module fp_round_dp
  import fp_round_pkg::*;
#(
  parameter int EXP_W       = 10,
  parameter int EXP_FIELD_W = 8,
  parameter int FRAC_W      = 23,
  parameter int EXTRA_W     = 3,
  localparam int KEEP_W     = FRAC_W + 1,
  localparam int SIG_W      = KEEP_W + EXTRA_W,
  localparam int WORD_W     = 1 + EXP_FIELD_W + FRAC_W
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] expIn,
  input  logic [SIG_W-1:0]        sig,
  input  rnd_mode_e               mode,
  input  sel_t                    sel,
  output logic                    sigZero,
  output logic                    expLow,
  output logic                    tinyAfter,
  output logic                    ovfNorm,
  output logic                    nxNorm,
  output logic                    nxDen,
  output logic [WORD_W-1:0]       word
);

  localparam int SH_W   = $clog2(SIG_W + 1);
  localparam int EXP_MAX = (1 << EXP_FIELD_W) - 2;
  localparam logic signed [EXP_W:0] EXP_MAX_S = (EXP_W+1)'(EXP_MAX);

  // normal path: round the significand at the fraction LSB
  logic [KEEP_W-1:0] keepN;
  logic              guardN, stickyN, incN, carryN;
  logic [KEEP_W:0]   sumN;
  logic signed [EXP_W:0] expR;
  logic [FRAC_W-1:0] fracN;

  assign keepN   = sig[SIG_W-1:EXTRA_W];
  assign guardN  = sig[EXTRA_W-1];
  assign stickyN = |sig[EXTRA_W-2:0];
  assign incN    = roundInc(mode, sign, keepN[0], guardN, stickyN);
  assign sumN    = {1'b0, keepN} + {{KEEP_W{1'b0}}, incN};
  assign carryN  = sumN[KEEP_W];
  assign expR    = {expIn[EXP_W-1], expIn} + {{EXP_W{1'b0}}, carryN};
  assign fracN   = carryN ? sumN[FRAC_W:1] : sumN[FRAC_W-1:0];

  // denormal path: shift right by 1 - exponent with sticky collection
  logic [EXP_W:0]    shFull;
  logic [SH_W-1:0]   sh;
  logic [SIG_W-1:0]  lostMask, denSig;
  logic              lost;
  logic [KEEP_W-1:0] keepD, sumD;
  logic              guardD, stickyD, incD;

  assign shFull   = (EXP_W+1)'(1) - {expIn[EXP_W-1], expIn};
  assign sh       = (shFull > (EXP_W+1)'(SIG_W)) ? SH_W'(SIG_W) : shFull[SH_W-1:0];
  assign lostMask = ~({SIG_W{1'b1}} << sh);
  assign lost     = |(sig & lostMask);
  assign denSig   = (sig >> sh) | {{(SIG_W-1){1'b0}}, lost};
  assign keepD    = denSig[SIG_W-1:EXTRA_W];
  assign guardD   = denSig[EXTRA_W-1];
  assign stickyD  = |denSig[EXTRA_W-2:0];
  assign incD     = roundInc(mode, sign, keepD[0], guardD, stickyD);
  assign sumD     = keepD + {{(KEEP_W-1){1'b0}}, incD};

  // classification for the control
  assign sigZero   = (sig == '0);
  assign expLow    = expIn[EXP_W-1] || (expIn == '0);
  assign tinyAfter = expIn[EXP_W-1] || ((expIn == '0) && !carryN);
  assign ovfNorm   = !expLow && (expR > EXP_MAX_S);
  assign nxNorm    = guardN || stickyN;
  assign nxDen     = guardD || stickyD;

  // final result selection
  always_comb begin
    if (sel.zero)
      word = {sign, {(WORD_W-1){1'b0}}};
    else if (sel.inf)
      word = {sign, {EXP_FIELD_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (sel.maxFin)
      word = {sign, {(EXP_FIELD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    else if (sel.denorm)
      word = {sign, {(EXP_FIELD_W-1){1'b0}}, sumD};
    else
      word = {sign, expR[EXP_FIELD_W-1:0], fracN};
  end

endmodule

// File: rtl/fp_round_ctl.sv
module fp_round_ctl
  import fp_round_pkg::*;
(
  input  logic      sign,
  input  rnd_mode_e mode,
  input  logic      flushEn,
  input  logic      flushBefore,
  input  logic      tinyBefore,
  input  logic      sigZero,
  input  logic      expLow,
  input  logic      tinyAfter,
  input  logic      ovfNorm,
  input  logic      nxNorm,
  input  logic      nxDen,
  output sel_t      sel,
  output flags_t    flg
);

  logic toInf;

  always_comb begin
    case (mode)
      RND_NEAR_EVEN: toInf = 1'b1;
      RND_ZERO:      toInf = 1'b0;
      RND_UP:        toInf = !sign;
      default:       toInf = sign;
    endcase
  end

  always_comb begin
    sel = '0;
    flg = '0;
    if (sigZero) begin
      sel.zero = 1'b1;
    end else if (!expLow) begin
      if (ovfNorm) begin
        sel.inf    = toInf;
        sel.maxFin = !toInf;
        flg.of     = 1'b1;
        flg.nx     = 1'b1;
      end else begin
        flg.nx = nxNorm;
      end
    end else if (flushEn && flushBefore) begin
      sel.zero = 1'b1;
      flg.fz   = 1'b1;
    end else if (flushEn) begin
      flg.nx = nxDen;
      if (tinyAfter) begin
        sel.zero = 1'b1;
        flg.fz   = 1'b1;
      end else begin
        sel.denorm = 1'b1;
      end
    end else begin
      sel.denorm = 1'b1;
      flg.nx     = nxDen;
      flg.uf     = nxDen && (tinyBefore || tinyAfter);
    end
  end

endmodule

// File: rtl/fp_round_outreg.sv
module fp_round_outreg
  import fp_round_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] wordIn,
  input  flags_t            flagsIn,
  output logic              outValid,
  output logic [WORD_W-1:0] wordOut,
  output flags_t            flagsOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      flagsOut <= '0;
      wordOut  <= '0;
    end else begin
      outValid <= inValid;
      flagsOut <= inValid ? flagsIn : '0;
      if (inValid) wordOut <= wordIn;
    end
  end

endmodule

// File: rtl/fp_round_ftz.sv
module fp_round_ftz
  import fp_round_pkg::*;
#(
  parameter int EXP_W       = 10,
  parameter int EXP_FIELD_W = 8,
  parameter int FRAC_W      = 23,
  parameter int EXTRA_W     = 3,
  localparam int SIG_W      = FRAC_W + 1 + EXTRA_W,
  localparam int WORD_W     = 1 + EXP_FIELD_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [SIG_W-1:0]        inSig,
  input  logic [1:0]              rndMode,
  input  logic                    flushEn,
  input  logic                    flushBefore,
  input  logic                    tinyBefore,
  output logic                    outValid,
  output logic [WORD_W-1:0]       outWord,
  output logic                    flagOverflow,
  output logic                    flagUnderflow,
  output logic                    flagInexact,
  output logic                    flagFlushed
);

  rnd_mode_e         mode;
  sel_t              sel;
  flags_t            flg, flgQ;
  logic              sigZero, expLow, tinyAfter, ovfNorm, nxNorm, nxDen;
  logic [WORD_W-1:0] word;

  assign mode = rnd_mode_e'(rndMode);

  fp_round_dp #(
    .EXP_W(EXP_W), .EXP_FIELD_W(EXP_FIELD_W), .FRAC_W(FRAC_W), .EXTRA_W(EXTRA_W)
  ) u_dp (
    .sign(inSign), .expIn(inExp), .sig(inSig), .mode(mode), .sel(sel),
    .sigZero(sigZero), .expLow(expLow), .tinyAfter(tinyAfter),
    .ovfNorm(ovfNorm), .nxNorm(nxNorm), .nxDen(nxDen), .word(word)
  );

  fp_round_ctl u_ctl (
    .sign(inSign), .mode(mode), .flushEn(flushEn), .flushBefore(flushBefore),
    .tinyBefore(tinyBefore), .sigZero(sigZero), .expLow(expLow),
    .tinyAfter(tinyAfter), .ovfNorm(ovfNorm), .nxNorm(nxNorm), .nxDen(nxDen),
    .sel(sel), .flg(flg)
  );

  fp_round_outreg #(.WORD_W(WORD_W)) u_reg (
    .clk(clk), .rst(rst), .inValid(inValid), .wordIn(word), .flagsIn(flg),
    .outValid(outValid), .wordOut(outWord), .flagsOut(flgQ)
  );

  assign flagOverflow  = flgQ.of;
  assign flagUnderflow = flgQ.uf;
  assign flagInexact   = flgQ.nx;
  assign flagFlushed   = flgQ.fz;

endmodule

// File: rtl/fp_round_ftz_chk.sv
module fp_round_ftz_chk #(
  parameter int EXP_FIELD_W = 8,
  parameter int FRAC_W      = 23,
  localparam int WORD_W     = 1 + EXP_FIELD_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord,
  input logic              flagOverflow,
  input logic              flagUnderflow,
  input logic              flagInexact,
  input logic              flagFlushed
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R1
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !(flagOverflow || flagUnderflow || flagInexact || flagFlushed));
  // R4
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    flagOverflow |-> flagInexact);
  // R4
  ovf_exp_chk: assert property (@(posedge clk) disable iff (rst)
    flagOverflow |-> (outWord[WORD_W-2:FRAC_W] >= {{(EXP_FIELD_W-1){1'b1}}, 1'b0}));
  // R7
  uf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    flagUnderflow |-> flagInexact);
  // R8
  fz_no_uf_chk: assert property (@(posedge clk) disable iff (rst)
    flagFlushed |-> !flagUnderflow);
  // R9
  fz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flagFlushed |-> (outWord[WORD_W-2:0] == '0));

endmodule

bind fp_round_ftz fp_round_ftz_chk #(.EXP_FIELD_W(EXP_FIELD_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .outWord(outWord),
  .flagOverflow(flagOverflow), .flagUnderflow(flagUnderflow),
  .flagInexact(flagInexact), .flagFlushed(flagFlushed)
);

// File: tb/fp_round_ftz_bench.sv
module fp_round_ftz_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NV         = 31;

  typedef struct packed {
    logic [1:0]        mode;
    logic              fEn;
    logic              fBef;
    logic              tBef;
    logic              sign;
    logic signed [9:0] ex;
    logic [26:0]       sig;
    logic [31:0]       word;
    logic [3:0]        flags;   // {overflow, underflow, inexact, flushed}
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h4000000, 32'h3F800000, 4'b0000},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h4000004, 32'h3F800000, 4'b0010},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h400000C, 32'h3F800002, 4'b0010},
    '{2'd1,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h400000C, 32'h3F800001, 4'b0010},
    '{2'd2,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h4000001, 32'h3F800001, 4'b0010},
    '{2'd2,1'b0,1'b0,1'b0,1'b1, 10'sd127, 27'h4000001, 32'hBF800000, 4'b0010},
    '{2'd3,1'b0,1'b0,1'b0,1'b1, 10'sd127, 27'h4000001, 32'hBF800001, 4'b0010},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd127, 27'h7FFFFFC, 32'h40000000, 4'b0010},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd254, 27'h7FFFFFC, 32'h7F800000, 4'b1010},
    '{2'd1,1'b0,1'b0,1'b0,1'b0, 10'sd255, 27'h4000000, 32'h7F7FFFFF, 4'b1010},
    '{2'd2,1'b0,1'b0,1'b0,1'b1, 10'sd300, 27'h4000000, 32'hFF7FFFFF, 4'b1010},
    '{2'd3,1'b0,1'b0,1'b0,1'b1, 10'sd255, 27'h4000000, 32'hFF800000, 4'b1010},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd254, 27'h7FFFFF8, 32'h7F7FFFFF, 4'b0000},
    '{2'd0,1'b0,1'b0,1'b1,1'b0, 10'sd0,   27'h4000000, 32'h00400000, 4'b0000},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, -10'sd22, 27'h4000000, 32'h00000001, 4'b0000},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, -10'sd23, 27'h4000000, 32'h00000000, 4'b0110},
    '{2'd2,1'b0,1'b0,1'b0,1'b0, -10'sd23, 27'h4000000, 32'h00000001, 4'b0110},
    '{2'd0,1'b0,1'b0,1'b1,1'b0, -10'sd23, 27'h4000001, 32'h00000001, 4'b0110},
    '{2'd1,1'b0,1'b0,1'b0,1'b1, -10'sd40, 27'h4000000, 32'h80000000, 4'b0110},
    '{2'd0,1'b0,1'b0,1'b1,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00800000, 4'b0110},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00800000, 4'b0010},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 10'sd0,   27'h4000004, 32'h00400000, 4'b0110},
    '{2'd0,1'b1,1'b1,1'b0,1'b1, 10'sd0,   27'h7FFFFFC, 32'h80000000, 4'b0001},
    '{2'd0,1'b1,1'b1,1'b0,1'b0, -10'sd5,  27'h4000001, 32'h00000000, 4'b0001},
    '{2'd0,1'b1,1'b1,1'b0,1'b0, 10'sd1,   27'h4000000, 32'h00800000, 4'b0000},
    '{2'd0,1'b1,1'b0,1'b0,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00800000, 4'b0010},
    '{2'd1,1'b1,1'b0,1'b0,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00000000, 4'b0011},
    '{2'd0,1'b1,1'b0,1'b0,1'b0, 10'sd0,   27'h4000000, 32'h00000000, 4'b0001},
    '{2'd0,1'b1,1'b0,1'b1,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00800000, 4'b0010},
    '{2'd0,1'b0,1'b0,1'b0,1'b1, 10'sd50,  27'h0000000, 32'h80000000, 4'b0000},
    '{2'd0,1'b0,1'b1,1'b1,1'b0, 10'sd0,   27'h7FFFFFC, 32'h00800000, 4'b0110}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inSign = 1'b0;
  logic signed [9:0] inExp = '0;
  logic [26:0]       inSig = '0;
  logic [1:0]        rndMode = '0;
  logic              flushEn = 1'b0;
  logic              flushBefore = 1'b0;
  logic              tinyBefore = 1'b0;
  logic              outValid;
  logic [31:0]       outWord;
  logic              flagOverflow, flagUnderflow, flagInexact, flagFlushed;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_ftz u_fp_round_ftz (
    .clk(clk), .rst(rst), .inValid(inValid), .inSign(inSign), .inExp(inExp),
    .inSig(inSig), .rndMode(rndMode), .flushEn(flushEn), .flushBefore(flushBefore),
    .tinyBefore(tinyBefore), .outValid(outValid), .outWord(outWord),
    .flagOverflow(flagOverflow), .flagUnderflow(flagUnderflow),
    .flagInexact(flagInexact), .flagFlushed(flagFlushed)
  );

  function automatic string reqTag(int i);
    case (i)
      1, 16, 17:           return "R3";
      8, 9, 10, 11, 12:    return "R4";
      13, 14, 19:          return "R5";
      15, 18:              return "R6";
      20, 21:              return "R7";
      22, 23, 24:          return "R8";
      25, 26, 27:          return "R9";
      28, 30:              return "R10";
      default:             return "R2";
    endcase
  endfunction

  function automatic logic [3:0] curFlags();
    return {flagOverflow, flagUnderflow, flagInexact, flagFlushed};
  endfunction

  task automatic checkOut(string tag, logic expValid, logic [31:0] expWord,
                          logic [3:0] expFlags, bit cmpWord);
    checks++;
    if (outValid !== expValid || curFlags() !== expFlags ||
        (cmpWord && outWord !== expWord)) begin
      failures++;
      $display("FAIL %s valid=%b/%b word=%h/%h flags=%b/%b (actual/expected)",
               tag, outValid, expValid, outWord, expWord, curFlags(), expFlags);
    end
  endtask

  task automatic drive(int i);
    inValid     = 1'b1;
    rndMode     = VECS[i].mode;
    flushEn     = VECS[i].fEn;
    flushBefore = VECS[i].fBef;
    tinyBefore  = VECS[i].tBef;
    inSign      = VECS[i].sign;
    inExp       = VECS[i].ex;
    inSig       = VECS[i].sig;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with inValid high during reset
    inValid = 1'b1;
    inSig   = 27'h4000000;
    inExp   = 10'sd255;
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 32'h0, 4'b0000, 1'b0);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkOut("R1", 1'b0, 32'h0, 4'b0000, 1'b0);

    // vector table, back to back, each result one clock after its input
    for (int i = 0; i <= NV; i++) begin
      if (i > 0)
        checkOut(reqTag(i-1), 1'b1, VECS[i-1].word, VECS[i-1].flags, 1'b1);
      if (i < NV) drive(i);
      else inValid = 1'b0;
      @(negedge clk);
    end

    // R1: idle cycle after the table drops valid and clears flags
    checkOut("R1", 1'b0, 32'h0, 4'b0000, 1'b0);

    // R1: one-cycle latency on a single overflow input
    drive(8);
    @(negedge clk);
    checkOut("R1", 1'b1, VECS[8].word, VECS[8].flags, 1'b1);

    // R1: synchronous reset while input stays valid clears valid and flags
    rst = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, 32'h0, 4'b0000, 1'b0);
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    checkOut("R1", 1'b0, 32'h0, 4'b0000, 1'b0);

    // R10: flushBefore set while flush disabled, negative sign, RTZ far below range
    drive(18);
    flushBefore = 1'b1;
    @(negedge clk);
    checkOut("R10", 1'b1, 32'h80000000, 4'b0110, 1'b1);
    inValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule